// File: doc/BRIEF.md
# Inverted Page Table Chain Walker

This block translates a virtual page number, tagged with an address-space identifier, into a physical frame number. It uses an inverted table that has one entry for each physical frame, and a small anchor table indexed by a hash of the page number. Each inverted-table entry holds the page number and identifier mapped to that frame, a link to the next candidate, and a flag that marks the last entry of a chain. The frame number returned is the index of the matching entry.

A lookup arrives on a valid/ready request stream. The walker hashes the page number and reads the anchor. It then examines one chained entry per clock until it finds an entry whose page number and identifier both equal the request. It stops without a match when it reaches the last entry of the chain or when a configured hop limit runs out. The result leaves on a valid/ready response stream that carries either a frame number or a fault flag.

Both tables are register arrays. They are loaded through two plain write ports, one for anchors and one for entries, and software uses these ports to build the chains. Only one lookup is in flight at any time.

Top module: `ipt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every anchor is invalid, so any lookup faults.
- R2: The anchor index is formed in two steps. First, the upper half of the page number is XORed with the lower half. Then bit i of that half-width value is XORed into index bit (i mod HAT_W).
- R3: A hit requires that both the entry's page number and its identifier equal the request. On a hit, `rsp_fault` is 0 and `rsp_frame` is the index of the matching entry.
- R4: The walk starts at the head that the anchor gives and follows each entry's next field. It examines one entry per cycle. A hit on the n-th entry of the chain (counting from 0) raises `rsp_valid` n+2 clock edges after the edge that accepted the request.
- R5: An anchor whose valid bit is 0 produces a fault. `rsp_valid` then rises 1 edge after acceptance.
- R6: If the entry with its last flag set does not match, the walk ends with a fault. Its latency is (entries examined)+1.
- R7: The walk examines at most MAX_HOPS entries and reports a fault once that limit is exhausted. A match on the MAX_HOPS-th entry is still a hit.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response holds its value. It is retired on the edge where both are high.
- R9: `req_ready` is high only when no lookup is pending, so a request is accepted only on an edge where `req_ready` is high.
- R10: A configuration write, to an anchor or to an entry, takes effect for every lookup accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hat_we | input | 1 | Anchor write strobe |
| cfg_hat_idx | input | HAT_W | Anchor index to write |
| cfg_hat_valid | input | 1 | Anchor valid bit written |
| cfg_hat_head | input | FRAME_W | Anchor head entry written |
| cfg_ent_we | input | 1 | Entry write strobe |
| cfg_ent_idx | input | FRAME_W | Entry (frame) index to write |
| cfg_ent_vpn | input | VPN_W | Page number stored in the entry |
| cfg_ent_asid | input | ASID_W | Identifier stored in the entry |
| cfg_ent_next | input | FRAME_W | Link to the next entry in the chain |
| cfg_ent_last | input | 1 | Last-entry-of-chain flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_vpn | input | VPN_W | Requested page number |
| req_asid | input | ASID_W | Requested identifier |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_frame | output | FRAME_W | Frame number on a hit |
| rsp_fault | output | 1 | No matching entry was found |

## Verification
The assertions assume that configuration writes never happen while a lookup is being walked or held. The response-hit check reads the entry at the returned frame, and it would see a rewritten entry if such a write occurred. The bench therefore issues every table write only while the walker is idle, between complete request/response exchanges. It also holds `req_valid` for exactly the accepting edge, and it applies back-pressure only through `rsp_ready`. Random tables may contain link cycles on purpose, since the hop limit must end those walks.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_WALK = 2'd1,
    WS_RESP = 2'd2
  } walk_state_t;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 16,
  parameter int IDX_W = 3
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int HALF = VPN_W / 2;

  logic [HALF-1:0] fold;
  assign fold = vpn_i[HALF-1:0] ^ vpn_i[2*HALF-1:HALF];

  // Fold the half-width value down to the anchor index width (R2)
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < HALF; i++) begin
      idx_o[i % IDX_W] = idx_o[i % IDX_W] ^ fold[i];
    end
  end
endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
  parameter int VPN_W   = 16,
  parameter int ASID_W  = 4,
  parameter int FRAME_W = 4,
  parameter int HAT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hat_we,
  input  logic [HAT_W-1:0]   hat_widx,
  input  logic               hat_wvalid,
  input  logic [FRAME_W-1:0] hat_whead,
  input  logic               ent_we,
  input  logic [FRAME_W-1:0] ent_widx,
  input  logic [VPN_W-1:0]   ent_wvpn,
  input  logic [ASID_W-1:0]  ent_wasid,
  input  logic [FRAME_W-1:0] ent_wnext,
  input  logic               ent_wlast,
  input  logic [HAT_W-1:0]   hat_ridx,
  output logic               hat_rvalid,
  output logic [FRAME_W-1:0] hat_rhead,
  input  logic [FRAME_W-1:0] ent_ridx,
  output logic [VPN_W-1:0]   ent_rvpn,
  output logic [ASID_W-1:0]  ent_rasid,
  output logic [FRAME_W-1:0] ent_rnext,
  output logic               ent_rlast
);
  localparam int HAT_N  = 1 << HAT_W;
  localparam int FRAMES = 1 << FRAME_W;

  logic               anc_v    [HAT_N];
  logic [FRAME_W-1:0] anc_head [HAT_N];
  logic [VPN_W-1:0]   tab_vpn  [FRAMES];
  logic [ASID_W-1:0]  tab_asid [FRAMES];
  logic [FRAME_W-1:0] tab_next [FRAMES];
  logic               tab_last [FRAMES];

  for (genvar g = 0; g < HAT_N; g++) begin : g_anchor
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        anc_v[g]    <= 1'b0;
        anc_head[g] <= '0;
      end else if (hat_we && hat_widx == HAT_W'(g)) begin
        anc_v[g]    <= hat_wvalid;
        anc_head[g] <= hat_whead;
      end
    end
  end

  for (genvar g = 0; g < FRAMES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tab_vpn[g]  <= '0;
        tab_asid[g] <= '0;
        tab_next[g] <= '0;
        tab_last[g] <= 1'b1;
      end else if (ent_we && ent_widx == FRAME_W'(g)) begin
        tab_vpn[g]  <= ent_wvpn;
        tab_asid[g] <= ent_wasid;
        tab_next[g] <= ent_wnext;
        tab_last[g] <= ent_wlast;
      end
    end
  end

  assign hat_rvalid = anc_v[hat_ridx];
  assign hat_rhead  = anc_head[hat_ridx];
  assign ent_rvpn   = tab_vpn[ent_ridx];
  assign ent_rasid  = tab_asid[ent_ridx];
  assign ent_rnext  = tab_next[ent_ridx];
  assign ent_rlast  = tab_last[ent_ridx];

  // R10: an anchor write is visible on the next cycle
  p_anchor_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hat_we |=> (anc_v[$past(hat_widx)] == $past(hat_wvalid)));
endmodule

// File: rtl/ipt_walk.sv
module ipt_walk
  import ipt_pkg::*;
#(
  parameter int VPN_W    = 16,
  parameter int ASID_W   = 4,
  parameter int FRAME_W  = 4,
  parameter int MAX_HOPS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [ASID_W-1:0]  req_asid,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_fault,
  input  logic               anc_valid,
  input  logic [FRAME_W-1:0] anc_head,
  output logic [FRAME_W-1:0] ent_idx,
  input  logic [VPN_W-1:0]   ent_vpn,
  input  logic [ASID_W-1:0]  ent_asid,
  input  logic [FRAME_W-1:0] ent_next,
  input  logic               ent_last
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  walk_state_t        state;
  logic [VPN_W-1:0]   key_vpn;
  logic [ASID_W-1:0]  key_asid;
  logic [FRAME_W-1:0] ptr;
  logic [HOP_W-1:0]   hops;
  logic               res_fault;
  logic               hit;
  logic               budget_out;

  assign hit        = (ent_vpn == key_vpn) && (ent_asid == key_asid);
  assign budget_out = (hops == HOP_W'(MAX_HOPS - 1));
  assign ent_idx    = ptr;
  assign req_ready  = (state == WS_IDLE);
  assign rsp_valid  = (state == WS_RESP);
  assign rsp_frame  = ptr;
  assign rsp_fault  = res_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      key_vpn   <= '0;
      key_asid  <= '0;
      ptr       <= '0;
      hops      <= '0;
      res_fault <= 1'b0;
    end else begin
      unique case (state)
        WS_IDLE: if (req_valid) begin
          key_vpn  <= req_vpn;
          key_asid <= req_asid;
          hops     <= '0;
          if (!anc_valid) begin
            ptr       <= '0;
            res_fault <= 1'b1;
            state     <= WS_RESP;
          end else begin
            ptr   <= anc_head;
            state <= WS_WALK;
          end
        end
        WS_WALK: begin
          if (hit) begin
            res_fault <= 1'b0;
            state     <= WS_RESP;
          end else if (ent_last || budget_out) begin
            ptr       <= '0;
            res_fault <= 1'b1;
            state     <= WS_RESP;
          end else begin
            ptr  <= ent_next;
            hops <= hops + 1'b1;
          end
        end
        WS_RESP: if (rsp_ready) state <= WS_IDLE;
        default: state <= WS_IDLE;
      endcase
    end
  end

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame) && $stable(rsp_fault)));

  p_rsp_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsp_valid) |-> $past(rsp_ready));

  p_one_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_empty_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !anc_valid) |=> (rsp_valid && rsp_fault));

  p_hit_keys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (ent_vpn == key_vpn && ent_asid == key_asid));
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int VPN_W    = 16,
  parameter int ASID_W   = 4,
  parameter int FRAME_W  = 4,
  parameter int HAT_W    = 3,
  parameter int MAX_HOPS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_hat_we,
  input  logic [HAT_W-1:0]   cfg_hat_idx,
  input  logic               cfg_hat_valid,
  input  logic [FRAME_W-1:0] cfg_hat_head,
  input  logic               cfg_ent_we,
  input  logic [FRAME_W-1:0] cfg_ent_idx,
  input  logic [VPN_W-1:0]   cfg_ent_vpn,
  input  logic [ASID_W-1:0]  cfg_ent_asid,
  input  logic [FRAME_W-1:0] cfg_ent_next,
  input  logic               cfg_ent_last,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [ASID_W-1:0]  req_asid,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_fault
);
  logic [HAT_W-1:0]   hash_idx;
  logic               anc_valid;
  logic [FRAME_W-1:0] anc_head;
  logic [FRAME_W-1:0] ent_idx;
  logic [VPN_W-1:0]   ent_vpn;
  logic [ASID_W-1:0]  ent_asid;
  logic [FRAME_W-1:0] ent_next;
  logic               ent_last;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(HAT_W)) u_hash (
    .vpn_i(req_vpn),
    .idx_o(hash_idx)
  );

  ipt_store #(.VPN_W(VPN_W), .ASID_W(ASID_W), .FRAME_W(FRAME_W), .HAT_W(HAT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .hat_we    (cfg_hat_we),
    .hat_widx  (cfg_hat_idx),
    .hat_wvalid(cfg_hat_valid),
    .hat_whead (cfg_hat_head),
    .ent_we    (cfg_ent_we),
    .ent_widx  (cfg_ent_idx),
    .ent_wvpn  (cfg_ent_vpn),
    .ent_wasid (cfg_ent_asid),
    .ent_wnext (cfg_ent_next),
    .ent_wlast (cfg_ent_last),
    .hat_ridx  (hash_idx),
    .hat_rvalid(anc_valid),
    .hat_rhead (anc_head),
    .ent_ridx  (ent_idx),
    .ent_rvpn  (ent_vpn),
    .ent_rasid (ent_asid),
    .ent_rnext (ent_next),
    .ent_rlast (ent_last)
  );

  ipt_walk #(.VPN_W(VPN_W), .ASID_W(ASID_W), .FRAME_W(FRAME_W), .MAX_HOPS(MAX_HOPS)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_vpn  (req_vpn),
    .req_asid (req_asid),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_frame(rsp_frame),
    .rsp_fault(rsp_fault),
    .anc_valid(anc_valid),
    .anc_head (anc_head),
    .ent_idx  (ent_idx),
    .ent_vpn  (ent_vpn),
    .ent_asid (ent_asid),
    .ent_next (ent_next),
    .ent_last (ent_last)
  );
endmodule

// File: tb/sim_ipt_walker.sv
`timescale 1ns/1ps
module sim_ipt_walker;
  localparam int VPN_W = 16, ASID_W = 4, FRAME_W = 4, HAT_W = 3, MAX_HOPS = 6;
  localparam int HAT_N = 1 << HAT_W, FRAMES = 1 << FRAME_W;

  logic clk = 0, rst_n = 0;
  logic cfg_hat_we = 0, cfg_hat_valid = 0, cfg_ent_we = 0, cfg_ent_last = 0;
  logic [HAT_W-1:0] cfg_hat_idx = '0;
  logic [FRAME_W-1:0] cfg_hat_head = '0, cfg_ent_idx = '0, cfg_ent_next = '0;
  logic [VPN_W-1:0] cfg_ent_vpn = '0, req_vpn = '0;
  logic [ASID_W-1:0] cfg_ent_asid = '0, req_asid = '0;
  logic req_valid = 0, rsp_ready = 0;
  logic req_ready, rsp_valid, rsp_fault;
  logic [FRAME_W-1:0] rsp_frame;

  int checks = 0, failures = 0, cycles = 0;

  // bench-side model of the tables
  bit               m_hv [HAT_N];
  int               m_hh [HAT_N];
  int               m_vpn [FRAMES];
  int               m_asid [FRAMES];
  int               m_next [FRAMES];
  bit               m_last [FRAMES];

  always #2.5 clk = ~clk;

  ipt_walker #(.VPN_W(VPN_W), .ASID_W(ASID_W), .FRAME_W(FRAME_W), .HAT_W(HAT_W),
               .MAX_HOPS(MAX_HOPS)) u0 (.*);

  function automatic int hash_of(int vpn);
    int lo, hi, f, idx;
    lo = vpn & 8'hFF; hi = (vpn >> 8) & 8'hFF; f = lo ^ hi; idx = 0;
    for (int i = 0; i < VPN_W / 2; i++) idx = idx ^ (((f >> i) & 1) << (i % HAT_W));
    return idx;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_hat(int idx, bit v, int head);
    @(negedge clk);
    cfg_hat_we = 1; cfg_hat_idx = HAT_W'(idx); cfg_hat_valid = v; cfg_hat_head = FRAME_W'(head);
    m_hv[idx] = v; m_hh[idx] = head;
    @(negedge clk); cfg_hat_we = 0;
  endtask

  task automatic wr_ent(int idx, int vpn, int asid, int nxt, bit last);
    @(negedge clk);
    cfg_ent_we = 1; cfg_ent_idx = FRAME_W'(idx); cfg_ent_vpn = VPN_W'(vpn);
    cfg_ent_asid = ASID_W'(asid); cfg_ent_next = FRAME_W'(nxt); cfg_ent_last = last;
    m_vpn[idx] = vpn; m_asid[idx] = asid; m_next[idx] = nxt; m_last[idx] = last;
    @(negedge clk); cfg_ent_we = 0;
  endtask

  // expected result from the requirements: fault flag, frame, latency
  task automatic model(int vpn, int asid, output bit flt, output int frm, output int lat);
    int h, p;
    h = hash_of(vpn); flt = 1; frm = 0;
    if (!m_hv[h]) begin lat = 1; return; end
    p = m_hh[h];
    for (int n = 0; n < MAX_HOPS; n++) begin
      if (m_vpn[p] == vpn && m_asid[p] == asid) begin flt = 0; frm = p; lat = n + 2; return; end
      if (m_last[p] || n == MAX_HOPS - 1) begin lat = n + 2; return; end
      p = m_next[p];
    end
    lat = MAX_HOPS + 1;
  endtask

  task automatic lookup(int vpn, int asid, string req, int stall);
    bit ef, gf; int ef_frm, elat, lat, gfrm;
    model(vpn, asid, ef, ef_frm, elat);
    @(negedge clk);
    check(req_ready === 1'b1, "R9", "ready when idle", req_ready, 1);
    req_valid = 1; req_vpn = VPN_W'(vpn); req_asid = ASID_W'(asid);
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (rsp_valid !== 1'b1 && lat < 40) begin
      check(req_ready === 1'b0, "R9", "ready while walking", req_ready, 0);
      @(negedge clk); lat++;
    end
    gf = rsp_fault; gfrm = rsp_frame;
    check(lat == elat, req, "latency", lat, elat);
    check(gf == ef, req, "fault", gf, ef);
    if (!ef) check(gfrm == ef_frm, req, "frame", gfrm, ef_frm);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && rsp_fault == gf && (gf || rsp_frame == gfrm), "R8",
            "held under back-pressure", rsp_frame, gfrm);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(rsp_valid === 1'b0, "R8", "retired after handshake", rsp_valid, 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int A, B, C, D;
    void'($urandom(32'd1234));
    for (int i = 0; i < HAT_N; i++) begin m_hv[i] = 0; m_hh[i] = 0; end
    for (int i = 0; i < FRAMES; i++) begin m_vpn[i] = 0; m_asid[i] = 0; m_next[i] = 0; m_last[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    lookup(16'h1234, 0, "R1", 0);   // all anchors empty: fault in one cycle (R5)

    A = 16'h0001; B = 16'h0100; C = 16'h0004; D = 16'h0006;
    // R2: A and B share an anchor; the hash pins the chain heads
    check(hash_of(A) == 1 && hash_of(B) == 1 && hash_of(C) == 4 && hash_of(D) == 6, "R2",
          "bench hash", hash_of(A), 1);
    // chain for hash 1: 5 -> 9 -> 3(last)
    wr_ent(5, B, 1, 9, 0); wr_ent(9, A, 2, 3, 0); wr_ent(3, A, 1, 0, 1);
    wr_hat(hash_of(A), 1, 5);
    lookup(A, 1, "R4", 2);          // third entry, latency 4
    lookup(A, 2, "R3", 0);          // same page, other id: frame 9
    lookup(A, 3, "R6", 1);          // no id match before last: fault
    lookup(B, 1, "R3", 0);          // head hit, frame 5
    lookup(16'h0202, 1, "R5", 0);   // hash 0 anchor empty
    // link loop for hash 4: 1 <-> 4, never matching
    wr_ent(1, 16'h7777, 0, 4, 0); wr_ent(4, 16'h7777, 0, 1, 0);
    wr_hat(hash_of(C), 1, 1);
    lookup(C, 0, "R7", 3);          // hop limit ends the loop
    // chain of exactly MAX_HOPS entries for hash 6, hit on the last
    for (int i = 10; i < 15; i++) wr_ent(i, 16'h1000 + i, 0, i + 1, 0);
    wr_ent(15, D, 0, 0, 0);
    wr_hat(hash_of(D), 1, 10);
    lookup(D, 0, "R7", 0);
    // R10: rewrite then look up again
    wr_ent(3, A, 5, 0, 1);
    lookup(A, 5, "R10", 0);
    wr_hat(hash_of(A), 0, 5);
    lookup(A, 2, "R10", 0);

    // constrained random tables and lookups
    for (int round = 0; round < 6; round++) begin
      for (int e = 0; e < FRAMES; e++)
        wr_ent(e, 16'h0100 * ($urandom % 4) + ($urandom % 8), $urandom % 3,
               $urandom % FRAMES, ($urandom % 4) == 0);
      for (int h = 0; h < HAT_N; h++) wr_hat(h, ($urandom % 5) != 0, $urandom % FRAMES);
      for (int k = 0; k < 50; k++) begin
        int v, a;
        if ($urandom % 2) v = m_vpn[$urandom % FRAMES];
        else v = 16'h0100 * ($urandom % 4) + ($urandom % 8);
        a = $urandom % 3;
        lookup(v, a, "R4", $urandom % 3);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule